// File: doc/BRIEF.md
# Built-In-Test Status Register with Warm-Reset Retention

This block is a single 8-bit control and status register on a byte-wide register bus. Software uses it to record the outcome of the board's built-in test, to set two test-option enables, and to ask for a board reset. Writing a one into the reset-request bit sends a one-cycle pulse to the external reset controller. That controller then resets the board and reports whether the reset was cold (power-on) or warm (self-requested).

The fields fall into two reset domains. The request bit and the two option enables return to their defaults on every reset. The test run status, the pass/fail flag and the "test has been run" flag are loaded with defaults only on a cold reset. A warm reset leaves them untouched, so firmware can read the test result after the reset that it requested. Reset is synchronous and active low. The reset-cause input is sampled in every clock cycle while reset is held.

The register answers at one decoded byte address. Its read data is combinational from the stored value. Reads at any other address return zero.

Top module: `bitsr_top`

## Requirements
- R1: A cold reset (`rst_n` low, `rst_cold` high at a clock edge) leaves the register reading 0x10: bit 4 (failed) is set and every other bit is clear.
- R2: A write at the decoded address stores bits 7, 6:5, 4, 3, 2 and 0 from `wdata` at that clock edge. The new value appears on `rdata` from then on. Bits 6:5 encode the run status: 00 never run, 01 fast test, 10 full test, 11 fast start.
- R3: Bit 1 is reserved. It always reads 0, and writes to it are ignored.
- R4: A warm reset (`rst_n` low, `rst_cold` low) clears bits 7, 3 and 2. It keeps bits 6:5, 4 and 0 as they were, so the register reads its previous value ANDed with 0x71.
- R5: A write that sets bit 7 while it was 0 raises `req_pulse` for exactly one clock cycle, starting at the same edge that stores the write.
- R6: Writing 1 to bit 7 while it is already 1 produces no pulse. Writing 0 to bit 7 clears it without a pulse.
- R7: A write at any other address leaves the register unchanged and produces no pulse. A read at any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rst_cold | input | 1 | Reset cause while reset is held: 1 = cold, 0 = warm |
| wr_en | input | 1 | Write strobe, sampled at the clock edge |
| addr | input | ADDR_W | Byte address for reads and writes |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data: register value at the decoded address, else 0 |
| req_pulse | output | 1 | One-cycle board reset request to the reset controller |

## Verification
All 256 write values are swept twice. The first sweep runs in ascending order, so bit 7 stays set through the upper half. This tells a rising-edge request apart from a level-triggered one, and shows that the reserved bit is masked. The second sweep precedes each warm reset with a different value. This separates the bits that are retained from those that are cleared, and a cold reset afterwards shows that the two reset causes are distinguished. Finally, every other address is written with the inverse of a known value that has bit 7 clear. This exposes any decode leak, including a stray request pulse.

// File: rtl/bitsr_pkg.sv
package bitsr_pkg;

    localparam int unsigned REG_W = 8;

    // bit positions that software decodes
    localparam int unsigned BIT_REQ    = 7;
    localparam int unsigned BIT_RUN_HI = 6;
    localparam int unsigned BIT_RUN_LO = 5;
    localparam int unsigned BIT_FAILED = 4;
    localparam int unsigned BIT_FASTEN = 3;
    localparam int unsigned BIT_FSTART = 2;
    localparam int unsigned BIT_RSVD   = 1;
    localparam int unsigned BIT_RAN    = 0;

    typedef enum logic [1:0] {
        RUN_NONE   = 2'b00,
        RUN_FAST   = 2'b01,
        RUN_FULL   = 2'b10,
        RUN_FSTART = 2'b11
    } run_state_e;

    typedef struct packed {
        logic       req;
        run_state_e run;
        logic       failed;
        logic       fast_en;
        logic       fstart_en;
        logic       ran;
    } bitsr_fields_t;

    localparam bitsr_fields_t COLD_DEFAULT = '{
        req:       1'b0,
        run:       RUN_NONE,
        failed:    1'b1,
        fast_en:   1'b0,
        fstart_en: 1'b0,
        ran:       1'b0
    };

    function automatic logic [REG_W-1:0] fields_to_byte(input bitsr_fields_t f);
        logic [REG_W-1:0] b;
        b                      = '0;
        b[BIT_REQ]             = f.req;
        b[BIT_RUN_HI:BIT_RUN_LO] = f.run;
        b[BIT_FAILED]          = f.failed;
        b[BIT_FASTEN]          = f.fast_en;
        b[BIT_FSTART]          = f.fstart_en;
        b[BIT_RSVD]            = 1'b0;
        b[BIT_RAN]             = f.ran;
        return b;
    endfunction

endpackage

// File: rtl/bitsr_decode.sv
module bitsr_decode #(
    parameter int unsigned          ADDR_W   = 8,
    parameter logic [ADDR_W-1:0]    REG_ADDR = 8'h5C
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    output logic              sel,
    output logic              wr_sel
);
    always_comb begin
        sel    = (addr == REG_ADDR);
        wr_sel = sel && wr_en;
    end
endmodule

// File: rtl/bitsr_fields.sv
module bitsr_fields
    import bitsr_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rst_cold,
    input  logic          wr_sel,
    input  bitsr_fields_t wr_val,
    output bitsr_fields_t fields_q
);
    bitsr_fields_t fields_d;

    always_comb begin
        fields_d = fields_q;
        if (!rst_n) begin
            if (rst_cold) begin
                fields_d = COLD_DEFAULT;
            end else begin
                // warm: only the volatile fields return to default
                fields_d.req       = COLD_DEFAULT.req;
                fields_d.fast_en   = COLD_DEFAULT.fast_en;
                fields_d.fstart_en = COLD_DEFAULT.fstart_en;
            end
        end else if (wr_sel) begin
            fields_d = wr_val;
        end
    end

    always_ff @(posedge clk) begin
        fields_q <= fields_d;
    end
endmodule

// File: rtl/bitsr_req_pulse.sv
module bitsr_req_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_sel,
    input  logic wr_req,
    input  logic req_now,
    output logic pulse_q
);
    logic pulse_d;

    always_comb begin
        pulse_d = 1'b0;
        if (rst_n) begin
            pulse_d = wr_sel && wr_req && !req_now;
        end
    end

    always_ff @(posedge clk) begin
        pulse_q <= pulse_d;
    end
endmodule

// File: rtl/bitsr_top.sv
module bitsr_top
    import bitsr_pkg::*;
#(
    parameter int unsigned       ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h5C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rst_cold,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic              req_pulse
);
    logic          sel;
    logic          wr_sel;
    bitsr_fields_t wr_val;
    bitsr_fields_t fields_q;
    logic [REG_W-1:0] reg_byte;
    logic          unused_rsvd_wbit;

    assign unused_rsvd_wbit = wdata[BIT_RSVD];

    always_comb begin
        wr_val.req       = wdata[BIT_REQ];
        wr_val.run       = run_state_e'(wdata[BIT_RUN_HI:BIT_RUN_LO]);
        wr_val.failed    = wdata[BIT_FAILED];
        wr_val.fast_en   = wdata[BIT_FASTEN];
        wr_val.fstart_en = wdata[BIT_FSTART];
        wr_val.ran       = wdata[BIT_RAN];
    end

    bitsr_decode #(
        .ADDR_W   (ADDR_W),
        .REG_ADDR (REG_ADDR)
    ) decode_i (
        .addr   (addr),
        .wr_en  (wr_en),
        .sel    (sel),
        .wr_sel (wr_sel)
    );

    bitsr_fields fields_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rst_cold (rst_cold),
        .wr_sel   (wr_sel),
        .wr_val   (wr_val),
        .fields_q (fields_q)
    );

    bitsr_req_pulse pulse_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_sel  (wr_sel),
        .wr_req  (wr_val.req),
        .req_now (fields_q.req),
        .pulse_q (req_pulse)
    );

    always_comb begin
        reg_byte = fields_to_byte(fields_q);
        rdata    = sel ? reg_byte : '0;
    end
endmodule

// File: rtl/bitsr_checker.sv
module bitsr_checker #(
    parameter int unsigned       ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h5C
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rst_cold,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        wdata,
    input logic [7:0]        reg_byte,
    input logic              req_pulse
);
    // R1: cold reset loads the power-on value
    assert_cold_default_R1: assert property (@(posedge clk)
        (!rst_n && rst_cold) |=> (reg_byte == 8'h10));

    // R2: a decoded write is stored in the writable bits
    assert_write_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == REG_ADDR) |=> ((reg_byte & 8'hFD) == ($past(wdata) & 8'hFD)));

    // R3: reserved bit never reads as one
    assert_rsvd_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_byte[1] == 1'b0);

    // R4: warm reset keeps retained fields and clears the rest
    assert_warm_keep_R4: assert property (@(posedge clk)
        (!rst_n && !rst_cold) |=> (reg_byte == ($past(reg_byte) & 8'h71)));

    // R5: pulse lasts one cycle and follows a decoded write of bit 7
    assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req_pulse |=> !req_pulse);
    assert_pulse_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req_pulse |-> ($past(wr_en) && $past(addr) == REG_ADDR && $past(wdata[7])));

    // R6: no pulse when the request bit was already set
    assert_no_repulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_byte[7] |=> !req_pulse);

    // R7: writes elsewhere leave the register alone
    assert_miss_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr != REG_ADDR) |=> ($stable(reg_byte) && !req_pulse));
endmodule

bind bitsr_top bitsr_checker #(
    .ADDR_W   (ADDR_W),
    .REG_ADDR (REG_ADDR)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_cold  (rst_cold),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .reg_byte  (reg_byte),
    .req_pulse (req_pulse)
);

// File: tb/bitsr_top_tb_top.sv
module bitsr_top_tb_top;
    localparam int unsigned       ADDR_W   = 8;
    localparam logic [ADDR_W-1:0] REG_ADDR = 8'h5C;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rst_cold = 1'b1;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] addr = REG_ADDR;
    logic [7:0]        wdata = 8'h00;
    logic [7:0]        rdata;
    logic              req_pulse;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    bitsr_top #(
        .ADDR_W   (ADDR_W),
        .REG_ADDR (REG_ADDR)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rst_cold  (rst_cold),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .req_pulse (req_pulse)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
        end
    endtask

    // drive at a falling edge, return at the next falling edge
    task automatic write_at(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_reg(output logic [7:0] v);
        addr = REG_ADDR;
        #1;
        v = rdata;
    endtask

    task automatic apply_reset(input logic cold);
        @(negedge clk);
        rst_n    = 1'b0;
        rst_cold = cold;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #1_000_000;
        checks++;
        failures++;
        $display("FAIL watchdog actual=0x00 expected=0x01");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic       prev_req;
        logic [7:0] base;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        read_reg(v);
        chk("R1 cold reset value", v, 8'h10);
        chk("R5 no pulse after reset", {7'b0, req_pulse}, 8'h00);

        // ascending sweep: request bit stays high through the upper half
        prev_req = 1'b0;
        for (int i = 0; i < 256; i++) begin
            write_at(REG_ADDR, 8'(i));
            chk("R5 R6 pulse on write", {7'b0, req_pulse},
                {7'b0, (i[7] && !prev_req)});
            read_reg(v);
            chk("R2 R3 readback", v, 8'(i) & 8'hFD);
            prev_req = i[7];
            @(negedge clk);
            chk("R5 pulse one cycle", {7'b0, req_pulse}, 8'h00);
        end
        // clear request without a pulse
        write_at(REG_ADDR, 8'h00);
        chk("R6 clear without pulse", {7'b0, req_pulse}, 8'h00);

        // warm reset retention sweep
        for (int i = 0; i < 256; i++) begin
            write_at(REG_ADDR, 8'(i));
            apply_reset(1'b0);
            read_reg(v);
            chk("R4 warm retention", v, 8'(i) & 8'h71);
            chk("R4 no pulse after warm", {7'b0, req_pulse}, 8'h00);
        end

        // cold reset after all ones
        write_at(REG_ADDR, 8'hFF);
        apply_reset(1'b1);
        read_reg(v);
        chk("R1 cold after all ones", v, 8'h10);

        // decode: every other address
        base = 8'h6D;
        write_at(REG_ADDR, base);
        for (int a = 0; a < 256; a++) begin
            if (8'(a) != REG_ADDR) begin
                write_at(8'(a), ~base);
                chk("R7 no pulse on miss", {7'b0, req_pulse}, 8'h00);
                addr = 8'(a);
                #1;
                chk("R7 miss read zero", rdata, 8'h00);
                read_reg(v);
                chk("R7 register unchanged", v, base & 8'hFD);
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule